// File: doc/BRIEF.md
# Pointer-Stepping Address Generator

This block turns an address-mode request into an effective address for a load/store or signal-processing loop. It holds a small bank of address registers. Each request names a mode, a pointer register, an index register, a signed 16-bit offset and an element size. On the clock edge that accepts the request, the block registers the effective address and, for the stepping modes, writes the updated pointer back into the bank.

The fixed-offset modes are plain, offset, two-register sum and offset-plus-scaled-index. The stepping modes are step-after and step-before. Two further modes confine a pointer to a ring buffer, and one walks a counter in mirrored-bit order for transform loops. The ring buffer's start and size and the mirror width come from configuration inputs that are held steady. A separate load port sets any address register directly.

Top module: `agu_core`

## Requirements
- R1: While `rst_n` is low, `ea_out` is 0 and `ea_valid` is 0, and every address register clears to 0.
- R2: When `wr_en` is high at a clock edge, register `wr_sel` takes `wr_data`. This happens even while `hold` is high, and it takes precedence over a pointer update to the same register on that edge.
- R3: Mode 0 (plain) gives `ea_out` = Rp and leaves Rp unchanged.
- R4: Mode 1 (offset) gives `ea_out` = Rp + `disp`, with `disp` sign-extended from 16 bits.
- R5: Mode 2 (two-register) gives `ea_out` = Rp + Rx.
- R6: Mode 3 (scaled) gives `ea_out` = Rp + sign-extended `disp` + (Rx << `esize`).
- R7: Mode 4 (step-after) gives `ea_out` = the old Rp, then Rp becomes Rp + (1 << `esize`).
- R8: Mode 5 (step-before) sets Rp to Rp − (1 << `esize`), and `ea_out` is that new value.
- R9: Mode 6 (ring step-after) gives `ea_out` = the old Rp. Rp then becomes Rp + d, except that a result at or above `cfg_cbase + cfg_clen` becomes `cfg_cbase`.
- R10: Mode 7 (ring step-before) works as follows. If Rp < `cfg_cbase` + d, Rp becomes `cfg_cbase + cfg_clen` − d; otherwise Rp becomes Rp − d. `ea_out` is the new Rp.
- R11: Mode 8 (mirrored) gives `ea_out` = `cfg_cbase` + the low N bits of Rp in reversed bit order, and Rp then increments by 1. N is `cfg_brev_n`, where 0 counts as 1 and anything above 16 counts as 16. For example, with N = 3, a counter of 3 gives an offset of 6.
- R12: A request is accepted when `req_valid` is high and `hold` is low. On the edge after an accepted request, `ea_out` and the pointer write-back take effect together and `ea_valid` is 1 for that cycle. Otherwise `ea_valid` is 0, `ea_out` keeps its value and no pointer changes.
- R13: Mode codes 9 to 15 act as plain mode: `ea_out` = Rp with no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| hold | input | 1 | Stall; blocks acceptance |
| mode | input | 4 | Address mode code |
| ptr_sel | input | 3 | Pointer register Rp |
| idx_sel | input | 3 | Index register Rx |
| disp | input | 16 | Signed offset |
| esize | input | 2 | log2 of element bytes, d = 1 << esize |
| cfg_cbase | input | 32 | Ring / mirror base address |
| cfg_clen | input | 32 | Ring length in bytes |
| cfg_brev_n | input | 5 | Mirror width N |
| wr_en | input | 1 | Register load enable |
| wr_sel | input | 3 | Register to load |
| wr_data | input | 32 | Load value |
| ea_out | output | 32 | Registered effective address |
| ea_valid | output | 1 | `ea_out` produced by the last edge |

## Verification
Every result appears exactly one edge after the request is accepted: `ea_out`, `ea_valid` and the written-back pointer all change on that edge. The bench drives inputs on the falling clock edge and checks on the next falling edge, so each check sees the result of exactly one rising edge.

A pointer update is never read directly. It is confirmed through the address that a later request produces, or by a plain-mode read one cycle after the stepping request. The hold, idle and load-port cases follow the same single-edge rule.

// File: rtl/agu_pkg.sv
package agu_pkg;
   typedef enum logic [3:0] {
      AM_PLAIN    = 4'd0,
      AM_OFFSET   = 4'd1,
      AM_TWOREG   = 4'd2,
      AM_SCALED   = 4'd3,
      AM_STEPPOST = 4'd4,
      AM_STEPPRE  = 4'd5,
      AM_RINGPOST = 4'd6,
      AM_RINGPRE  = 4'd7,
      AM_MIRROR   = 4'd8
   } agu_mode_e;
endpackage

// File: rtl/agu_bitrev.sv
// Mirrors the low n bits of din (n clamped to 1..W) into the low end of dout.
module agu_bitrev #(
   parameter int W  = 16,
   parameter int NW = 5
) (
   input  logic [W-1:0]  din,
   input  logic [NW-1:0] nbits,
   output logic [W-1:0]  dout
);
   localparam logic [NW-1:0] WN = NW'(W);

   if (W >= (1 << NW)) begin : g_bad_width
      $error("agu_bitrev: NW too narrow for W");
   end

   logic [W-1:0]  mir;
   logic [NW-1:0] n_eff;

   for (genvar i = 0; i < W; i++) begin : g_mirror
      assign mir[i] = din[W-1-i];
   end

   always_comb begin
      if (nbits == '0)     n_eff = NW'(1);
      else if (nbits > WN) n_eff = WN;
      else                 n_eff = nbits;
      dout = mir >> (WN - n_eff);
   end
endmodule

// File: rtl/agu_regfile.sv
// Address register bank: two read ports, one update port, one load port (load wins).
module agu_regfile #(
   parameter int AW   = 32,
   parameter int NREG = 8,
   localparam int SW  = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [SW-1:0] rd_a_sel,
   output logic [AW-1:0] rd_a,
   input  logic [SW-1:0] rd_b_sel,
   output logic [AW-1:0] rd_b,
   input  logic          upd_en,
   input  logic [SW-1:0] upd_sel,
   input  logic [AW-1:0] upd_data,
   input  logic          ld_en,
   input  logic [SW-1:0] ld_sel,
   input  logic [AW-1:0] ld_data
);
   logic [AW-1:0] regs [NREG];

   for (genvar i = 0; i < NREG; i++) begin : g_reg
      always_ff @(posedge clk) begin
         if (!rst_n)
            regs[i] <= '0;
         else if (ld_en && ld_sel == SW'(i))
            regs[i] <= ld_data;
         else if (upd_en && upd_sel == SW'(i))
            regs[i] <= upd_data;
      end
   end

   assign rd_a = regs[rd_a_sel];
   assign rd_b = regs[rd_b_sel];
endmodule

// File: rtl/agu_calc.sv
// Combinational address and next-pointer computation for all modes.
module agu_calc
   import agu_pkg::*;
#(
   parameter int AW  = 32,
   parameter int DW  = 16,
   parameter int BRW = 16,
   parameter int BNW = 5
) (
   input  logic [3:0]     mode,
   input  logic [AW-1:0]  ptr,
   input  logic [AW-1:0]  idx,
   input  logic [DW-1:0]  disp,
   input  logic [1:0]     esize,
   input  logic [AW-1:0]  cbase,
   input  logic [AW-1:0]  clen,
   input  logic [BNW-1:0] brev_n,
   output logic [AW-1:0]  ea,
   output logic [AW-1:0]  ptr_next,
   output logic           ptr_we
);
   logic [AW-1:0]  sdisp, step, ring_end, inc_v, dec_v;
   logic [BRW-1:0] mirrored;

   agu_bitrev #(.W(BRW), .NW(BNW)) u_rev (
      .din   (ptr[BRW-1:0]),
      .nbits (brev_n),
      .dout  (mirrored)
   );

   always_comb begin
      sdisp    = {{(AW-DW){disp[DW-1]}}, disp};
      step     = AW'(1) << esize;
      ring_end = cbase + clen;
      inc_v    = ptr + step;
      dec_v    = ptr - step;
      ea       = ptr;
      ptr_next = ptr;
      ptr_we   = 1'b0;
      case (mode)
         AM_OFFSET: ea = ptr + sdisp;
         AM_TWOREG: ea = ptr + idx;
         AM_SCALED: ea = ptr + sdisp + (idx << esize);
         AM_STEPPOST: begin
            ptr_next = inc_v;
            ptr_we   = 1'b1;
         end
         AM_STEPPRE: begin
            ptr_next = dec_v;
            ea       = dec_v;
            ptr_we   = 1'b1;
         end
         AM_RINGPOST: begin
            ptr_next = (inc_v >= ring_end) ? cbase : inc_v;
            ptr_we   = 1'b1;
         end
         AM_RINGPRE: begin
            ptr_next = (ptr < cbase + step) ? ring_end - step : dec_v;
            ea       = ptr_next;
            ptr_we   = 1'b1;
         end
         AM_MIRROR: begin
            ea       = cbase + AW'(mirrored);
            ptr_next = ptr + AW'(1);
            ptr_we   = 1'b1;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/agu_core.sv
// Top: register bank + calculator + registered address output.
module agu_core #(
   parameter int AW   = 32,
   parameter int NREG = 8,
   parameter int DW   = 16,
   localparam int SW  = $clog2(NREG)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          hold,
   input  logic [3:0]    mode,
   input  logic [SW-1:0] ptr_sel,
   input  logic [SW-1:0] idx_sel,
   input  logic [DW-1:0] disp,
   input  logic [1:0]    esize,
   input  logic [AW-1:0] cfg_cbase,
   input  logic [AW-1:0] cfg_clen,
   input  logic [4:0]    cfg_brev_n,
   input  logic          wr_en,
   input  logic [SW-1:0] wr_sel,
   input  logic [AW-1:0] wr_data,
   output logic [AW-1:0] ea_out,
   output logic          ea_valid
);
   if (AW < 17)     begin : g_bad_aw   $error("agu_core: AW must be at least 17"); end
   if (DW >= AW)    begin : g_bad_dw   $error("agu_core: DW must be below AW"); end
   if (NREG < 2)    begin : g_bad_nreg $error("agu_core: NREG must be at least 2"); end

   logic [AW-1:0] ptr_val, idx_val, ea_c, ptr_next;
   logic          ptr_we, accept;

   assign accept = req_valid && !hold;

   agu_regfile #(.AW(AW), .NREG(NREG)) u_bank (
      .clk      (clk),
      .rst_n    (rst_n),
      .rd_a_sel (ptr_sel),
      .rd_a     (ptr_val),
      .rd_b_sel (idx_sel),
      .rd_b     (idx_val),
      .upd_en   (accept && ptr_we),
      .upd_sel  (ptr_sel),
      .upd_data (ptr_next),
      .ld_en    (wr_en),
      .ld_sel   (wr_sel),
      .ld_data  (wr_data)
   );

   agu_calc #(.AW(AW), .DW(DW), .BRW(16), .BNW(5)) u_calc (
      .mode     (mode),
      .ptr      (ptr_val),
      .idx      (idx_val),
      .disp     (disp),
      .esize    (esize),
      .cbase    (cfg_cbase),
      .clen     (cfg_clen),
      .brev_n   (cfg_brev_n),
      .ea       (ea_c),
      .ptr_next (ptr_next),
      .ptr_we   (ptr_we)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ea_out   <= '0;
         ea_valid <= 1'b0;
      end else begin
         ea_valid <= accept;
         if (accept) ea_out <= ea_c;
      end
   end
endmodule

// File: rtl/agu_core_chk.sv
module agu_core_chk
   import agu_pkg::*;
#(
   parameter int AW = 32
) (
   input logic          clk,
   input logic          rst_n,
   input logic          req_valid,
   input logic          hold,
   input logic [3:0]    mode,
   input logic [1:0]    esize,
   input logic          wr_en,
   input logic [AW-1:0] cfg_cbase,
   input logic [AW-1:0] cfg_clen,
   input logic [AW-1:0] ptr_val,
   input logic [AW-1:0] ea_out,
   input logic          ea_valid
);
   logic ring_ok;
   assign ring_ok = ptr_val >= cfg_cbase && ptr_val < cfg_cbase + cfg_clen
                    && (AW'(1) << esize) <= cfg_clen && !wr_en;

   p_accept_valid_r12: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !hold) |=> ea_valid);

   p_hold_freeze_r12: assert property (@(posedge clk) disable iff (!rst_n)
      hold |=> (!ea_valid && $stable(ea_out)));

   p_idle_novalid_r12: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !ea_valid);

   p_ring_post_inside_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !hold && mode == AM_RINGPOST && ring_ok)
      |=> (ea_out >= $past(cfg_cbase) && ea_out < $past(cfg_cbase) + $past(cfg_clen)));

   p_ring_pre_inside_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !hold && mode == AM_RINGPRE && ring_ok)
      |=> (ea_out >= $past(cfg_cbase) && ea_out < $past(cfg_cbase) + $past(cfg_clen)));

   p_mirror_span_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !hold && mode == AM_MIRROR)
      |=> ((ea_out - $past(cfg_cbase)) < (AW'(1) << 16)));
endmodule

bind agu_core agu_core_chk #(.AW(AW)) u_chk (.*);

// File: tb/sim_agu_core.sv
`timescale 1ns/1ps
module sim_agu_core;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, hold = 1'b0, wr_en = 1'b0;
   logic [3:0]  mode = '0;
   logic [2:0]  ptr_sel = '0, idx_sel = '0, wr_sel = '0;
   logic [15:0] disp = '0;
   logic [1:0]  esize = '0;
   logic [31:0] cfg_cbase = 32'h100, cfg_clen = 32'h10, wr_data = '0;
   logic [4:0]  cfg_brev_n = 5'd3;
   logic [31:0] ea_out;
   logic        ea_valid;
   int checks = 0, errors = 0;

   always #2.5 clk = ~clk;

   agu_core u0 (.*);

   // {mode[63:60], p[59:57], x[56:54], disp[53:38], esize[37:36], req[35:32], expected ea[31:0]}
   localparam logic [63:0] VEC [0:25] = '{
      {4'd0, 3'd0, 3'd0, 16'h0000, 2'd0, 4'd3,  32'h1000}, // R3
      {4'd1, 3'd0, 3'd0, 16'h0010, 2'd0, 4'd4,  32'h1010}, // R4
      {4'd1, 3'd0, 3'd0, 16'hFFF0, 2'd0, 4'd4,  32'h0FF0}, // R4 negative
      {4'd2, 3'd0, 3'd1, 16'h0000, 2'd0, 4'd5,  32'h1020}, // R5
      {4'd3, 3'd0, 3'd1, 16'h0004, 2'd2, 4'd6,  32'h1084}, // R6
      {4'd4, 3'd2, 3'd0, 16'h0000, 2'd2, 4'd7,  32'h3000}, // R7
      {4'd0, 3'd2, 3'd0, 16'h0000, 2'd0, 4'd7,  32'h3004}, // R7 write-back
      {4'd5, 3'd2, 3'd0, 16'h0000, 2'd2, 4'd8,  32'h3000}, // R8
      {4'd5, 3'd2, 3'd0, 16'h0000, 2'd1, 4'd8,  32'h2FFE}, // R8 half step
      {4'd6, 3'd3, 3'd0, 16'h0000, 2'd2, 4'd9,  32'h0100}, // R9
      {4'd6, 3'd3, 3'd0, 16'h0000, 2'd2, 4'd9,  32'h0104},
      {4'd6, 3'd3, 3'd0, 16'h0000, 2'd2, 4'd9,  32'h0108},
      {4'd6, 3'd3, 3'd0, 16'h0000, 2'd2, 4'd9,  32'h010C},
      {4'd0, 3'd3, 3'd0, 16'h0000, 2'd0, 4'd9,  32'h0100}, // R9 wrapped
      {4'd7, 3'd3, 3'd0, 16'h0000, 2'd2, 4'd10, 32'h010C}, // R10 wrap
      {4'd7, 3'd3, 3'd0, 16'h0000, 2'd2, 4'd10, 32'h0108}, // R10
      {4'd8, 3'd4, 3'd0, 16'h0000, 2'd0, 4'd11, 32'h0100}, // R11 0->0
      {4'd8, 3'd4, 3'd0, 16'h0000, 2'd0, 4'd11, 32'h0104}, // R11 1->4
      {4'd8, 3'd4, 3'd0, 16'h0000, 2'd0, 4'd11, 32'h0102}, // R11 2->2
      {4'd8, 3'd4, 3'd0, 16'h0000, 2'd0, 4'd11, 32'h0106}, // R11 3->6
      {4'd9, 3'd5, 3'd0, 16'h0000, 2'd0, 4'd13, 32'h8000}, // R13
      {4'd0, 3'd5, 3'd0, 16'h0000, 2'd0, 4'd13, 32'h8000},
      {4'd15,3'd5, 3'd0, 16'h0000, 2'd3, 4'd13, 32'h8000}, // R13
      {4'd0, 3'd5, 3'd0, 16'h0000, 2'd0, 4'd13, 32'h8000},
      {4'd4, 3'd5, 3'd0, 16'h0000, 2'd3, 4'd7,  32'h8000}, // R7 eight-byte
      {4'd0, 3'd5, 3'd0, 16'h0000, 2'd0, 4'd7,  32'h8008}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic load(input logic [2:0] sel, input logic [31:0] val);
      wr_en = 1'b1; wr_sel = sel; wr_data = val;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic issue(input logic [3:0] m, input logic [2:0] p, input logic [1:0] es);
      req_valid = 1'b1; mode = m; ptr_sel = p; esize = es; disp = '0;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: run did not finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 ea_out", ea_out, 32'h0);
      chk("R1 ea_valid", {31'b0, ea_valid}, 32'h0);
      rst_n = 1'b1;
      issue(4'd0, 3'd7, 2'd0);
      chk("R1 register cleared", ea_out, 32'h0);

      load(3'd0, 32'h1000); load(3'd1, 32'h20);  load(3'd2, 32'h3000);
      load(3'd3, 32'h100);  load(3'd4, 32'h0);   load(3'd5, 32'h8000);

      for (int k = 0; k < 26; k++) begin
         req_valid = 1'b1;
         mode = VEC[k][63:60]; ptr_sel = VEC[k][59:57]; idx_sel = VEC[k][56:54];
         disp = VEC[k][53:38]; esize = VEC[k][37:36];
         @(negedge clk);
         chk($sformatf("R%0d vector %0d", VEC[k][35:32], k), ea_out, VEC[k][31:0]);
         chk($sformatf("R12 valid vector %0d", k), {31'b0, ea_valid}, 32'h1);
      end
      req_valid = 1'b0;

      // R12: idle cycle
      @(negedge clk);
      chk("R12 idle valid", {31'b0, ea_valid}, 32'h0);
      chk("R12 idle ea held", ea_out, 32'h8008);

      // R12: hold blocks a stepping request
      hold = 1'b1;
      issue(4'd4, 3'd5, 2'd3);
      chk("R12 hold valid", {31'b0, ea_valid}, 32'h0);
      chk("R12 hold ea held", ea_out, 32'h8008);
      hold = 1'b0;
      issue(4'd0, 3'd5, 2'd0);
      chk("R12 hold no write-back", ea_out, 32'h8008);

      // R2: load beats a same-cycle pointer update
      wr_en = 1'b1; wr_sel = 3'd2; wr_data = 32'h5550;
      issue(4'd4, 3'd2, 2'd2);
      wr_en = 1'b0;
      chk("R2 old pointer used", ea_out, 32'h2FFE);
      issue(4'd0, 3'd2, 2'd0);
      chk("R2 load wins", ea_out, 32'h5550);

      // R2: load works under hold
      hold = 1'b1; wr_en = 1'b1; wr_sel = 3'd6; wr_data = 32'h777;
      issue(4'd0, 3'd6, 2'd0);
      hold = 1'b0; wr_en = 1'b0;
      issue(4'd0, 3'd6, 2'd0);
      chk("R2 load under hold", ea_out, 32'h777);

      // R11: width clamps
      load(3'd4, 32'h1);
      cfg_brev_n = 5'd0;
      issue(4'd8, 3'd4, 2'd0);
      chk("R11 width 0 as 1", ea_out, 32'h101);
      cfg_brev_n = 5'd20;
      issue(4'd8, 3'd4, 2'd0);
      chk("R11 width 20 as 16", ea_out, 32'h4100);
      cfg_brev_n = 5'd16;
      issue(4'd8, 3'd4, 2'd0);
      chk("R11 width 16", ea_out, 32'hC100);

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule